// File: doc/BRIEF.md
# Multicycle Five-Step RISC Core

This block is a small processor core that runs one instruction at a time and spends a different number of clock cycles on each, according to its class. An instruction is first fetched. Its operands are then read and its immediate is sign-extended. After that come an arithmetic step, a data-memory step and a register write-back, and each step is held in its own working register. A branch ends after its operand read. A store ends after its memory step. Every other instruction uses all five steps. The core contains its own 32 x 32-bit register file, a word-addressed instruction memory and a word-addressed data memory, so it needs nothing else to run a program.

Programs are written into the instruction memory through a valid/ready load port while `run` is low. The load port moves data, so it is a valid/ready stream. A word transfers on a rising edge where `prog_valid` and `prog_ready` are both high. `prog_ready` is high only while the core is parked in its fetch step with `run` low. A word offered at any other time is held back, and the source keeps `prog_valid`, `prog_addr` and `prog_data` stable until the word is accepted. When `run` goes high, the core executes from address 0 after reset. When `run` goes low again, the current instruction finishes and the core parks before the next fetch. `retire` pulses in the final cycle of every instruction and `retire_count` counts the instructions completed. Both let a user measure how many cycles each class takes.

Top module: `mc_core`

## Requirements
- R1: After reset, `pc` is 0, `retire_count` is 0, `retire` is low, every register reads 0, and with `run` low `prog_ready` is high.
- R2: A non-branch instruction at address P leaves `pc` at P+4. `pc` changes only on the edge that ends the cycle in which `retire` is high.
- R3: With `run` held high, a branch takes 2 cycles from fetch to `retire`, a store takes 4, and every other opcode takes 5. The next instruction's fetch starts in the cycle after `retire`.
- R4: Register-register ops use opcode 0x00 with rd in bits 15:11 and rs in bits 25:21. The function field, bits 5:0, selects the operation: add = 0x20, subtract (rs-rt) = 0x22, and = 0x24, or = 0x25, xor = 0x26, signed set-less-than = 0x2A. Any other function value writes 0.
- R5: Immediate ops take opcodes 0x08 add, 0x0C and, 0x0D or and 0x0E xor. Each combines rs with the sign-extended bits 15:0 and writes rt (bits 20:16).
- R6: Load word (0x23) writes rt with the data word at byte address rs+imm. Store word (0x2B) writes rt's value to that address. Bits 1:0 of the address are ignored.
- R7: Branch-if-zero (0x04) tests rs. If rs is 0 the branch is taken and `pc` becomes P+4+(imm<<2). Otherwise `pc` becomes P+4.
- R8: Register 0 always reads 0. Writes to it are discarded.
- R9: `retire_count` rises by exactly one per `retire` pulse and holds otherwise.
- R10: A program word is written only on an edge where `prog_valid` and `prog_ready` are both high. `prog_ready` is low while `run` is high or an instruction is under way.
- R11: When `run` drops, the instruction already under way still completes. The core then holds `pc` and `retire_count` until `run` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execute when high; park at the next fetch when low |
| prog_valid | input | 1 | A program word is offered |
| prog_ready | output | 1 | The instruction memory can take a word |
| prog_addr | input | IAW | Word index of the offered program word |
| prog_data | input | 32 | Instruction word |
| peek_idx | input | 5 | Register index for the observation read port |
| peek_data | output | 32 | Current value of register `peek_idx` |
| pc | output | 32 | Byte address of the current instruction |
| retire | output | 1 | High in the last cycle of an instruction |
| retire_count | output | 32 | Number of instructions completed since reset |

## Verification
The bench builds the core with its default sizes: 64-word instruction and data memories and 32-bit data. This is enough for a sixteen-word program that ends in a branch-to-self loop, and for store/load offsets that land on a chosen data word. With these values every instruction class, a taken forward branch, an untaken branch and a taken backward branch can be reached, each timed against its expected cycle count. An attempt to write register 0 and a negative immediate can also be reached. Stopping inside the backward loop then exercises the park-at-fetch rule and the count freeze.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM, ST_WB
  } step_t;

  typedef enum logic [2:0] {
    CL_RR, CL_RI, CL_LOAD, CL_STORE, CL_BRANCH, CL_OTHER
  } iclass_t;

  typedef enum logic [2:0] {
    AOP_ADD, AOP_SUB, AOP_AND, AOP_OR, AOP_XOR, AOP_SLT, AOP_ZERO
  } aop_t;

  localparam logic [5:0] OPC_RR   = 6'h00;
  localparam logic [5:0] OPC_BEQZ = 6'h04;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  function automatic iclass_t classify(input logic [5:0] opc);
    case (opc)
      OPC_RR:                                  return CL_RR;
      OPC_ADDI, OPC_ANDI, OPC_ORI, OPC_XORI:   return CL_RI;
      OPC_LW:                                  return CL_LOAD;
      OPC_SW:                                  return CL_STORE;
      OPC_BEQZ:                                return CL_BRANCH;
      default:                                 return CL_OTHER;
    endcase
  endfunction

  function automatic aop_t pick_aop(input logic [5:0] opc, input logic [5:0] fn);
    if (opc == OPC_RR) begin
      case (fn)
        6'h20:   return AOP_ADD;
        6'h22:   return AOP_SUB;
        6'h24:   return AOP_AND;
        6'h25:   return AOP_OR;
        6'h26:   return AOP_XOR;
        6'h2A:   return AOP_SLT;
        default: return AOP_ZERO;
      endcase
    end
    case (opc)
      OPC_ANDI: return AOP_AND;
      OPC_ORI:  return AOP_OR;
      OPC_XORI: return AOP_XOR;
      default:  return AOP_ADD;
    endcase
  endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [RAW-1:0] ra1,
  input  logic [RAW-1:0] ra2,
  input  logic [RAW-1:0] ra3,
  output logic [W-1:0]   rd1,
  output logic [W-1:0]   rd2,
  output logic [W-1:0]   rd3,
  input  logic           we,
  input  logic [RAW-1:0] wa,
  input  logic [W-1:0]   wd
);
  logic [W-1:0] cells [NREG];

  assign cells[0] = '0;

  // shared write data, per-register enable from the decoded address
  for (genvar i = 1; i < NREG; i++) begin : g_cell
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           q <= '0;
      else if (we && wa == RAW'(i))         q <= wd;
    end
    assign cells[i] = q;
  end

  assign rd1 = cells[ra1];
  assign rd2 = cells[ra2];
  assign rd3 = cells[ra3];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  aop_t         op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] z
);
  always_comb begin
    case (op)
      AOP_ADD: z = x + y;
      AOP_SUB: z = x - y;
      AOP_AND: z = x & y;
      AOP_OR:  z = x | y;
      AOP_XOR: z = x ^ y;
      AOP_SLT: z = W'($signed(x) < $signed(y));
      default: z = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  iclass_t cls,
  output step_t   step,
  output logic    last
);
  step_t nxt;

  always_comb begin
    nxt  = step;
    last = 1'b0;
    case (step)
      ST_FETCH:  if (run) nxt = ST_DECODE;
      ST_DECODE: if (cls == CL_BRANCH) begin nxt = ST_FETCH; last = 1'b1; end
                 else nxt = ST_EXEC;
      ST_EXEC:   nxt = ST_MEM;
      ST_MEM:    if (cls == CL_STORE) begin nxt = ST_FETCH; last = 1'b1; end
                 else nxt = ST_WB;
      ST_WB:     begin nxt = ST_FETCH; last = 1'b1; end
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= ST_FETCH;
    else        step <= nxt;
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int W          = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           prog_valid,
  output logic           prog_ready,
  input  logic [IAW-1:0] prog_addr,
  input  logic [31:0]    prog_data,
  input  logic [4:0]     peek_idx,
  output logic [W-1:0]   peek_data,
  output logic [W-1:0]   pc,
  output logic           retire,
  output logic [31:0]    retire_count
);
  step_t        step;
  iclass_t      cls;
  aop_t         aop;
  logic [31:0]  ir;
  logic [W-1:0] npc, a_q, b_q, imm_q, alu_out, lmd;
  logic         cond;
  logic [W-1:0] rs_val, rt_val, sext, alu_y, alu_z, br_tgt;
  logic         rf_we;
  logic [4:0]   rf_wa;
  logic [W-1:0] rf_wd;

  logic [31:0]  imem [IMEM_WORDS];
  logic [W-1:0] dmem [DMEM_WORDS];

  assign cls    = classify(ir[31:26]);
  assign aop    = pick_aop(ir[31:26], ir[5:0]);
  assign sext   = W'($signed(ir[15:0]));
  assign br_tgt = npc + (sext << 2);

  mc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .run(run), .cls(cls), .step(step), .last(retire)
  );

  mc_regfile #(.W(W), .NREG(32)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(ir[25:21]), .ra2(ir[20:16]), .ra3(peek_idx),
    .rd1(rs_val), .rd2(rt_val), .rd3(peek_data),
    .we(rf_we), .wa(rf_wa), .wd(rf_wd)
  );

  assign alu_y = (cls == CL_RR) ? b_q : imm_q;

  mc_alu #(.W(W)) u_alu (.op(aop), .x(a_q), .y(alu_y), .z(alu_z));

  assign prog_ready = (step == ST_FETCH) && !run;

  always_ff @(posedge clk) begin
    if (prog_valid && prog_ready) imem[prog_addr] <= prog_data;
  end

  // working registers, one register-transfer group per step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; npc <= '0; ir <= '0; a_q <= '0; b_q <= '0;
      imm_q <= '0; alu_out <= '0; lmd <= '0; cond <= 1'b0;
    end else begin
      case (step)
        ST_FETCH: if (run) begin
          ir  <= imem[pc[IAW+1:2]];
          npc <= pc + W'(4);
        end
        ST_DECODE: begin
          a_q   <= rs_val;
          b_q   <= rt_val;
          imm_q <= sext;
          if (cls == CL_BRANCH) begin
            alu_out <= br_tgt;
            cond    <= (rs_val == '0);
            pc      <= (rs_val == '0) ? br_tgt : npc;
          end
        end
        ST_EXEC: alu_out <= alu_z;
        ST_MEM:  if (cls == CL_LOAD) lmd <= dmem[alu_out[DAW+1:2]];
        default: ;
      endcase
      if (retire && cls != CL_BRANCH) pc <= npc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
    end else if (step == ST_MEM && cls == CL_STORE) begin
      dmem[alu_out[DAW+1:2]] <= b_q;
    end
  end

  assign rf_we = (step == ST_WB) && (cls == CL_RR || cls == CL_RI || cls == CL_LOAD);
  assign rf_wa = (cls == CL_RR) ? ir[15:11] : ir[20:16];
  assign rf_wd = (cls == CL_LOAD) ? lmd : alu_out;

  always_ff @(posedge clk) begin
    if (!rst_n)      retire_count <= '0;
    else if (retire) retire_count <= retire_count + 32'd1;
  end
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input step_t        step,
  input iclass_t      cls,
  input logic [W-1:0] pc,
  input logic         retire,
  input logic [31:0]  retire_count,
  input logic         prog_ready,
  input logic [4:0]   peek_idx,
  input logic [W-1:0] peek_data
);
  assert_next_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> step == ST_FETCH);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> retire_count == $past(retire_count) + 32'd1);

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(retire_count));

  assert_pc_only_on_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(pc));

  assert_pc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && cls != CL_BRANCH) |=> pc == $past(pc) + W'(4));

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    peek_idx == 5'd0 |-> peek_data == '0);

  assert_ready_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ready |-> step == ST_FETCH && !retire);
endmodule

bind mc_core mc_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .cls(cls), .pc(pc), .retire(retire),
  .retire_count(retire_count), .prog_ready(prog_ready),
  .peek_idx(peek_idx), .peek_data(peek_data)
);

// File: tb/test_mc_core.sv
module test_mc_core;
  localparam int IAW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           run = 1'b0;
  logic           prog_valid = 1'b0;
  logic           prog_ready;
  logic [IAW-1:0] prog_addr = '0;
  logic [31:0]    prog_data = '0;
  logic [4:0]     peek_idx = '0;
  logic [31:0]    peek_data, pc, retire_count;
  logic           retire;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  bit counting = 0;
  int cyc = 0, n_ret = 0;

  typedef struct { logic [31:0] addr; int cycles; } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  mc_core i_mc_core (
    .clk(clk), .rst_n(rst_n), .run(run), .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data), .peek_idx(peek_idx), .peek_data(peek_data),
    .pc(pc), .retire(retire), .retire_count(retire_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] ri(input logic [5:0] opc, input int rt, input int rs, input int imm);
    return {opc, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic expect_retire(input int addr, input int cycles);
    exp_t e;
    e.addr = 32'(addr);
    e.cycles = cycles;
    sb.push_back(e);
  endtask

  task automatic load_word(input int idx, input logic [31:0] w);
    prog_valid = 1'b1; prog_addr = IAW'(idx); prog_data = w;
    do @(posedge clk); while (!prog_ready);
    @(negedge clk);
    prog_valid = 1'b0;
  endtask

  task automatic peek(input string req, input int idx, input logic [31:0] exp);
    peek_idx = 5'(idx);
    #1;
    chk(req, peek_data, exp);
  endtask

  // monitor: times each instruction and pops the scoreboard
  always @(negedge clk) begin
    if (counting) begin
      cyc++;
      chk("R10 ready low while running", {31'd0, prog_ready}, 32'd0);
      if (retire) begin
        if (sb.size() == 0) begin
          n_run++; n_fail++;
          $display("FAIL R3: unexpected retire at pc %h expected none", pc);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R2/R7 instruction address", pc, e.addr);
          chk("R3 cycles per class", 32'(cyc), 32'(e.cycles));
        end
        cyc = 0;
        n_ret++;
        if (n_ret == 17) begin
          run = 1'b0;       // R11: stop inside the backward loop
          counting = 0;
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc, 32'd0);
    chk("R1 count", retire_count, 32'd0);
    chk("R1 retire", {31'd0, retire}, 32'd0);
    chk("R1 ready", {31'd0, prog_ready}, 32'd1);
    peek("R1 reg clear", 7, 32'd0);

    load_word(0,  ri(6'h08, 1, 0, 5));         // addi r1 = 5
    load_word(1,  ri(6'h08, 2, 0, -3));        // addi r2 = -3
    load_word(2,  rr(6'h20, 3, 1, 2));         // add r3
    load_word(3,  rr(6'h22, 4, 1, 2));         // sub r4
    load_word(4,  ri(6'h2B, 3, 0, 8));         // sw r3 -> byte 8
    load_word(5,  ri(6'h23, 5, 1, 3));         // lw r5 <- 5+3
    load_word(6,  ri(6'h08, 0, 0, 7));         // write r0
    load_word(7,  ri(6'h04, 0, 0, 1));         // beqz r0 taken, skip 8
    load_word(8,  ri(6'h08, 6, 0, 99));        // skipped
    load_word(9,  ri(6'h04, 0, 1, 5));         // beqz r1 not taken
    load_word(10, rr(6'h26, 7, 1, 2));         // xor
    load_word(11, rr(6'h25, 8, 1, 2));         // or
    load_word(12, rr(6'h24, 9, 1, 2));         // and
    load_word(13, rr(6'h2A, 10, 2, 1));        // slt
    load_word(14, ri(6'h0E, 11, 1, 16'h0010)); // xori
    load_word(15, ri(6'h04, 0, 0, -1));        // self loop

    expect_retire(0, 5);  expect_retire(4, 5);  expect_retire(8, 5);
    expect_retire(12, 5); expect_retire(16, 4); expect_retire(20, 5);
    expect_retire(24, 5); expect_retire(28, 2); expect_retire(36, 2);
    expect_retire(40, 5); expect_retire(44, 5); expect_retire(48, 5);
    expect_retire(52, 5); expect_retire(56, 5);
    for (int k = 0; k < 3; k++) expect_retire(60, 2);

    cyc = 0;
    counting = 1;
    run = 1'b1;
    wait (n_ret == 17);
    repeat (10) @(negedge clk);

    chk("R11 count frozen", retire_count, 32'd17);
    chk("R9 count total", retire_count, 32'd17);
    chk("R11 pc parked", pc, 32'd60);
    chk("R10 ready after stop", {31'd0, prog_ready}, 32'd1);
    chk("R3 scoreboard drained", 32'(sb.size()), 32'd0);

    peek("R5 addi", 1, 32'd5);
    peek("R5 addi negative", 2, 32'hFFFF_FFFD);
    peek("R4 add", 3, 32'd2);
    peek("R4 sub", 4, 32'd8);
    peek("R6 store then load", 5, 32'd2);
    peek("R8 r0 write discarded", 0, 32'd0);
    peek("R7 taken branch skipped", 6, 32'd0);
    peek("R4 xor", 7, 32'hFFFF_FFF8);
    peek("R4 or", 8, 32'hFFFF_FFFD);
    peek("R4 and", 9, 32'd5);
    peek("R4 slt signed", 10, 32'd1);
    peek("R5 xori", 11, 32'h0000_0015);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule